// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block sits in front of a non-linear pipeline, one in which an operation uses some stages more than once. Each cycle it decides whether a waiting operation may enter the pipeline. The decision rests on a collision vector. Bit i-1 of that vector is set when a second operation launched i cycles after a first would collide with it in some stage.

The controller keeps a state register of the same width. On every clock the register shifts one place toward bit 0, and a zero enters the top. A request is granted only when bit 0 of the state is clear. A granted launch ORs the collision vector into the shifted state, which records the reservations of the new operation on top of those already in flight. An all-zero state means the pipeline is empty.

A synchronous clear empties the state. A new vector may be loaded only while the state is empty. The state is brought out so that the exact sequence of states can be compared against a model.

Top module: `cv_issue_ctrl`

## Requirements
- R1: After the asynchronous reset, the state is all zeros and the active vector equals the parameter `INIT_VEC` (default 0b00111). Both `initiate` and `stall` are low while `req` is low.
- R2: `initiate` is high in exactly those cycles where `req` is high, `clear` is low and bit 0 of the state is 0.
- R3: `stall` is high in exactly those cycles where `req` is high, `clear` is low and bit 0 of the state is 1. It is never high together with `initiate`.
- R4: In a cycle without a launch and without a clear, the next state is the current state shifted right by one, with 0 entering the top bit.
- R5: In a launch cycle, the next state is the right-shifted state bitwise ORed with the vector in force in that cycle.
- R6: When `clear` is high, the next state is all zeros and no launch occurs in that cycle. A request in the following cycle is granted.
- R7: A vector load presented while the state is non-zero is ignored. Later launches keep the spacing of the old vector.
- R8: A load presented while the state is all zeros takes effect in that same cycle. A launch in that cycle already uses the new vector.
- R9: With vector 0b00111 and a request held high, successive launches are exactly 4 cycles apart. With vector 0b00011 they are 3 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the state (pipeline empty) |
| req | input | 1 | An operation is waiting to be launched |
| load_en | input | 1 | Load `load_vec` as the collision vector (only when the state is empty) |
| load_vec | input | W | New collision vector; bit i-1 marks latency i as forbidden |
| initiate | output | 1 | Launch granted this cycle |
| stall | output | 1 | Request held off this cycle |
| state | output | W | Current reservation state |

## Verification
Two pairs of functions can fall in the same cycle: a vector load together with a launch from the empty state, and a clear together with a pending request. The bench provokes both deliberately. After the same-cycle load, the spacing to the next launch must follow the new vector. After the clear, no grant may appear in that cycle, and a grant must appear in the next. A random request, load and clear stream then runs against a behavioural reference model. The model compares the grant, the stall and the full state every cycle.

// File: rtl/cv_issue_ctrl.sv
module cv_issue_ctrl #(
  parameter int W = 5,
  parameter logic [W-1:0] INIT_VEC = {{(W-3){1'b0}}, 3'b111}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         req,
  input  logic         load_en,
  input  logic [W-1:0] load_vec,
  output logic         initiate,
  output logic         stall,
  output logic [W-1:0] state
);

  logic [W-1:0] st_q, base_q;

  wire          empty = (st_q == '0);
  wire          take  = load_en && empty;
  wire [W-1:0]  vec   = take ? load_vec : base_q;
  wire          go    = req && !clear && !st_q[0];

  assign initiate = go;
  assign stall    = req && !clear && st_q[0];
  assign state    = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      base_q <= INIT_VEC;
    end else begin
      if (take)
        base_q <= load_vec;
      if (clear)
        st_q <= '0;
      else
        st_q <= (st_q >> 1) | (go ? vec : '0);
    end
  end

  // R3
  excl_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(initiate && stall));

  // R3
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> state[0]);

  // R4
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!initiate && !clear) |=> (state == ($past(state) >> 1)));

  // R5
  launch_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (initiate && base_q[0] && !load_en) |=> state[0]);

  // R6
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (state == '0));

  // R7
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != '0) |=> $stable(base_q));

endmodule

// File: tb/cv_issue_ctrl_test.sv
module cv_issue_ctrl_test;
  localparam int W = 5;

  logic clk = 0, rst_n = 0, clear = 0, req = 0, load_en = 0;
  logic [W-1:0] load_vec = '0;
  logic initiate, stall;
  logic [W-1:0] state;

  int total = 0, bad = 0;
  int ms = 0, mb = 7;
  bit got_init;
  bit done = 0;

  always #5 clk = ~clk;

  cv_issue_ctrl #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .req(req), .load_en(load_en),
    .load_vec(load_vec), .initiate(initiate), .stall(stall), .state(state));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit r, bit ld, int v, bit c);
    int eff;
    bit go;
    req = r; load_en = ld; load_vec = W'(v); clear = c;
    #1;
    go  = r && !c && ((ms & 1) == 0);
    eff = (ld && ms == 0) ? v : mb;
    chk("R2 initiate", int'(initiate), int'(go));
    chk("R3 stall", int'(stall), int'(r && !c && (ms & 1)));
    got_init = initiate;
    if (ld && ms == 0) mb = v;
    if (c) ms = 0;
    else   ms = (ms >> 1) | (go ? eff : 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4/R5 state", int'(state), ms);
  endtask

  task automatic gap(output int k);
    k = 0;
    do begin
      step(1, 0, 0, 0);
      k++;
    end while (!got_init && k < 20);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (2) @(negedge clk);
    // R1
    chk("R1 state", int'(state), 0);
    chk("R1 initiate", int'(initiate), 0);
    chk("R1 stall", int'(stall), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 state after release", int'(state), 0);

    // R9: default vector spacing
    step(1, 0, 0, 0);
    chk("R9 first launch", int'(got_init), 1);
    gap(k); chk("R9 gap 00111", k, 4);
    gap(k); chk("R9 gap repeat", k, 4);

    // R6: clear with pending request, grant next cycle
    step(1, 0, 0, 1);
    chk("R6 no launch in clear", int'(got_init), 0);
    step(1, 0, 0, 0);
    chk("R6 grant after clear", int'(got_init), 1);

    // R7: load while busy ignored
    step(0, 1, 1, 0);
    repeat (5) step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R7 launch", int'(got_init), 1);
    gap(k); chk("R7 old spacing kept", k, 4);

    // R8: load and launch same cycle from empty
    repeat (5) step(0, 0, 0, 0);
    step(1, 1, 3, 0);
    chk("R8 launch with load", int'(got_init), 1);
    chk("R8 state uses new vector", int'(state), 3);
    gap(k); chk("R9 gap 00011", k, 3);

    // random stream against model
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
           int'($urandom_range(0, 31)), $urandom_range(0, 40) == 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule